// File: doc/BRIEF.md
# Transmit Sync Header Sequencer

This block produces the leading bits of every transmit frame as a serial stream. After a start pulse it sends a synchronization run of logic-one bits whose length is programmable, then a 16-bit start-of-frame word, then the header and payload bits pulled from an upstream bit stream until that stream marks its final bit. Scrambling happens later in the chain, so all bits leave here unscrambled.

One bit is produced for each symbol-enable pulse. Each bit is presented for one cycle with a valid strobe. A companion flag travels with every bit and tells the modulator to use differential BPSK for the whole synchronization run and the start word, whatever rate the payload uses. Preamble length and start word are captured when the start pulse is accepted. The inputs may then change freely while the frame is being sent.

Top module: `frame_sync_gen`

## Requirements
- R1: During and right after reset, `bit_vld_o`, `force_dbpsk_o` and `up_ready_o` are all 0.
- R2: `start_i` is accepted only while no frame is in progress. A start pulse during a frame has no effect on the length, start word or content of that frame, and it does not begin a second frame.
- R3: The frame begins with L bits of value 1. L is `pre_len_i` captured at the accepted start, except that 0 gives L=1 and values above 256 give L=256.
- R4: Directly after the preamble, the 16 bits of `sfd_i` captured at the accepted start are sent with bit 0 first and bit 15 last.
- R5: After the start word, upstream bits are sent in the order they were accepted. The bit accepted together with `up_last_i`=1 is the last bit of the frame, and no bit follows it until a new start.
- R6: `force_dbpsk_o` is 1 from the cycle after a start is accepted and with every preamble and start-word bit. It is 0 with every upstream data bit.
- R7: A bit is presented (`bit_vld_o`=1 for one cycle) only in the cycle after a clock edge at which `sym_en_i` was 1, and at most one bit per symbol-enable pulse.
- R8: `up_ready_o` is 1 only during the data part of a frame, and only in cycles where `sym_en_i` is 1. A symbol-enable pulse in the data part while `up_valid_i` is 0 presents no bit and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a frame |
| pre_len_i | input | 9 | Preamble length in bits, captured at start |
| sfd_i | input | 16 | Start-of-frame word, captured at start |
| sym_en_i | input | 1 | Symbol-enable pulse, one bit per pulse |
| up_data_i | input | 1 | Upstream header/payload bit |
| up_valid_i | input | 1 | Upstream bit is available |
| up_last_i | input | 1 | Upstream bit is the final bit of the frame |
| up_ready_o | output | 1 | Upstream bit is taken at this edge when valid |
| bit_o | output | 1 | Serial output bit |
| bit_vld_o | output | 1 | Output bit strobe |
| force_dbpsk_o | output | 1 | Forces differential BPSK for the current bit |

## Verification
The checker tracks frames from the port handshake alone. It assumes that `up_valid_i`, `up_data_i` and `up_last_i` stay within one frame's stream: no `up_last_i` before the final bit, and no upstream bits offered after it until the next start. It also assumes that `sfd_i` and `pre_len_i` are meaningful only at the accepted start. The stimulus keeps to this. The upstream model offers payload bits only while its per-frame pointer is short of the frame's length, raises `up_last_i` only on the final one, and deliberately scrambles the length and start-word inputs after the start so that any failure to capture them shows at the outputs.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    localparam int unsigned PRE_MAX_DEF = 256;
    localparam int unsigned SFD_W_DEF   = 16;
    localparam logic [15:0] SFD_DEF     = 16'hF3A0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_SFD  = 2'd2,
        ST_DATA = 2'd3
    } fsg_state_e;

    typedef enum logic [1:0] {
        EM_NONE = 2'd0,
        EM_PRE  = 2'd1,
        EM_SFD  = 2'd2,
        EM_DATA = 2'd3
    } fsg_emit_e;

    typedef struct packed {
        logic vld;
        logic val;
        logic sync;
    } fsg_bit_t;

    function automatic logic fsg_is_sync(input fsg_emit_e em);
        return (em == EM_PRE) || (em == EM_SFD);
    endfunction

endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
    import fsg_pkg::*;
#(
    parameter int unsigned PRE_MAX = PRE_MAX_DEF,
    parameter int unsigned SFD_W   = SFD_W_DEF,
    parameter int unsigned LEN_W   = $clog2(PRE_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] pre_len_i,
    input  logic             sym_en_i,
    input  logic             up_valid_i,
    input  logic             up_last_i,
    output logic             accept_o,
    output fsg_emit_e        emit_o,
    output logic             up_ready_o
);

    localparam int unsigned SIDX_W = $clog2(SFD_W);
    localparam int unsigned CNT_W  = (LEN_W > SIDX_W) ? LEN_W : SIDX_W;

    fsg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] len_q, len_d, len_clamped;
    logic             pre_done, sfd_done;

    // Length limits: zero means one bit, anything past the maximum saturates.
    always_comb begin
        if (pre_len_i == '0) begin
            len_clamped = LEN_W'(1);
        end else if (pre_len_i > LEN_W'(PRE_MAX)) begin
            len_clamped = LEN_W'(PRE_MAX);
        end else begin
            len_clamped = pre_len_i;
        end
    end

    assign pre_done = (cnt_q == (CNT_W'(len_q) - CNT_W'(1)));
    assign sfd_done = (cnt_q == CNT_W'(SFD_W - 1));

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        len_d      = len_q;
        emit_o     = EM_NONE;
        accept_o   = 1'b0;
        up_ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    len_d    = len_clamped;
                    cnt_d    = '0;
                    state_d  = ST_PRE;
                end
            end
            ST_PRE: begin
                if (sym_en_i) begin
                    emit_o = EM_PRE;
                    if (pre_done) begin
                        cnt_d   = '0;
                        state_d = ST_SFD;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_SFD: begin
                if (sym_en_i) begin
                    emit_o = EM_SFD;
                    if (sfd_done) begin
                        cnt_d   = '0;
                        state_d = ST_DATA;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                up_ready_o = sym_en_i;
                if (sym_en_i && up_valid_i) begin
                    emit_o = EM_DATA;
                    if (up_last_i) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= LEN_W'(1);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
        end
    end

endmodule

// File: rtl/fsg_sfd_shift.sv
module fsg_sfd_shift #(
    parameter int unsigned       SFD_W     = 16,
    parameter logic [SFD_W-1:0]  SFD_RST   = '0,
    parameter bit                LSB_FIRST = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [SFD_W-1:0] pat_i,
    input  logic             shift_i,
    output logic             bit_o
);

    logic [SFD_W-1:0] sh_q;

    if (LSB_FIRST) begin : g_lsb
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q <= SFD_RST;
            end else if (load_i) begin
                sh_q <= pat_i;
            end else if (shift_i) begin
                sh_q <= {1'b0, sh_q[SFD_W-1:1]};
            end
        end
        assign bit_o = sh_q[0];
    end else begin : g_msb
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q <= SFD_RST;
            end else if (load_i) begin
                sh_q <= pat_i;
            end else if (shift_i) begin
                sh_q <= {sh_q[SFD_W-2:0], 1'b0};
            end
        end
        assign bit_o = sh_q[SFD_W-1];
    end

endmodule

// File: rtl/fsg_out_stage.sv
module fsg_out_stage
    import fsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     arm_i,
    input  fsg_bit_t nxt_i,
    output logic     bit_o,
    output logic     vld_o,
    output logic     force_o
);

    logic bit_q, vld_q, force_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q   <= 1'b0;
            vld_q   <= 1'b0;
            force_q <= 1'b0;
        end else begin
            vld_q <= nxt_i.vld;
            if (nxt_i.vld) begin
                bit_q <= nxt_i.val;
            end
            if (arm_i) begin
                force_q <= 1'b1;
            end else if (nxt_i.vld) begin
                force_q <= nxt_i.sync;
            end
        end
    end

    assign bit_o   = bit_q;
    assign vld_o   = vld_q;
    assign force_o = force_q;

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
    import fsg_pkg::*;
#(
    parameter int unsigned      PRE_MAX   = PRE_MAX_DEF,
    parameter int unsigned      SFD_W     = SFD_W_DEF,
    parameter logic [SFD_W-1:0] SFD_RST   = SFD_W'(SFD_DEF),
    parameter bit               LSB_FIRST = 1'b1,
    localparam int unsigned     LEN_W     = $clog2(PRE_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] pre_len_i,
    input  logic [SFD_W-1:0] sfd_i,
    input  logic             sym_en_i,
    input  logic             up_data_i,
    input  logic             up_valid_i,
    input  logic             up_last_i,
    output logic             up_ready_o,
    output logic             bit_o,
    output logic             bit_vld_o,
    output logic             force_dbpsk_o
);

    logic      accept;
    fsg_emit_e emit;
    logic      sfd_bit;
    fsg_bit_t  nxt;

    fsg_ctrl #(
        .PRE_MAX (PRE_MAX),
        .SFD_W   (SFD_W),
        .LEN_W   (LEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .pre_len_i  (pre_len_i),
        .sym_en_i   (sym_en_i),
        .up_valid_i (up_valid_i),
        .up_last_i  (up_last_i),
        .accept_o   (accept),
        .emit_o     (emit),
        .up_ready_o (up_ready_o)
    );

    fsg_sfd_shift #(
        .SFD_W     (SFD_W),
        .SFD_RST   (SFD_RST),
        .LSB_FIRST (LSB_FIRST)
    ) u_sfd (
        .clk     (clk),
        .rst     (rst),
        .load_i  (accept),
        .pat_i   (sfd_i),
        .shift_i (emit == EM_SFD),
        .bit_o   (sfd_bit)
    );

    always_comb begin
        nxt.vld  = (emit != EM_NONE);
        nxt.sync = fsg_is_sync(emit);
        unique case (emit)
            EM_PRE:  nxt.val = 1'b1;
            EM_SFD:  nxt.val = sfd_bit;
            EM_DATA: nxt.val = up_data_i;
            default: nxt.val = 1'b0;
        endcase
    end

    fsg_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (accept),
        .nxt_i   (nxt),
        .bit_o   (bit_o),
        .vld_o   (bit_vld_o),
        .force_o (force_dbpsk_o)
    );

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter int unsigned PRE_MAX = 256,
    parameter int unsigned SFD_W   = 16,
    parameter int unsigned LEN_W   = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [LEN_W-1:0] pre_len_i,
    input logic [SFD_W-1:0] sfd_i,
    input logic             sym_en_i,
    input logic             up_data_i,
    input logic             up_valid_i,
    input logic             up_last_i,
    input logic             up_ready_o,
    input logic             bit_o,
    input logic             bit_vld_o,
    input logic             force_dbpsk_o
);

    localparam int unsigned VC_W   = LEN_W + 2;
    localparam int unsigned SIDX_W = $clog2(SFD_W);

    logic             busy;
    logic [VC_W-1:0]  vcount, len_c, rel, sync_end;
    logic [SFD_W-1:0] sfd_c;
    logic [LEN_W-1:0] len_lim;

    always_comb begin
        if (pre_len_i == '0) begin
            len_lim = LEN_W'(1);
        end else if (pre_len_i > LEN_W'(PRE_MAX)) begin
            len_lim = LEN_W'(PRE_MAX);
        end else begin
            len_lim = pre_len_i;
        end
    end

    assign rel      = vcount - len_c;
    assign sync_end = len_c + VC_W'(SFD_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            vcount <= '0;
            len_c  <= VC_W'(1);
            sfd_c  <= '0;
        end else if (!busy && start_i) begin
            busy   <= 1'b1;
            vcount <= '0;
            len_c  <= VC_W'(len_lim);
            sfd_c  <= sfd_i;
        end else begin
            if (busy && up_valid_i && up_ready_o && up_last_i) begin
                busy <= 1'b0;
            end
            if (bit_vld_o && (vcount != '1)) begin
                vcount <= vcount + VC_W'(1);
            end
        end
    end

    // R7: a presented bit always follows a symbol-enable edge
    a_r7_vld_needs_enable: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |-> $past(sym_en_i));

    // R8: upstream is taken only inside a frame and on a symbol enable
    a_r8_ready_gated: assert property (@(posedge clk) disable iff (rst)
        up_ready_o |-> (sym_en_i && busy));

    // R3: the first L bits of a frame are ones
    a_r3_preamble_ones: assert property (@(posedge clk) disable iff (rst)
        (bit_vld_o && (vcount < len_c)) |-> bit_o);

    // R4: start word follows, bit 0 first
    a_r4_sfd_order: assert property (@(posedge clk) disable iff (rst)
        (bit_vld_o && (vcount >= len_c) && (vcount < sync_end))
            |-> (bit_o == sfd_c[rel[SIDX_W-1:0]]));

    // R6: forced modulation with every sync bit, released for data
    a_r6_force_sync: assert property (@(posedge clk) disable iff (rst)
        (bit_vld_o && (vcount < sync_end)) |-> force_dbpsk_o);

    a_r6_force_data: assert property (@(posedge clk) disable iff (rst)
        (bit_vld_o && (vcount >= sync_end)) |-> !force_dbpsk_o);

    // R5: a data bit is the upstream bit offered at the previous edge
    a_r5_data_passthru: assert property (@(posedge clk) disable iff (rst)
        (bit_vld_o && !force_dbpsk_o) |-> (bit_o == $past(up_data_i)));

endmodule

bind frame_sync_gen fsg_checker #(
    .PRE_MAX (PRE_MAX),
    .SFD_W   (SFD_W),
    .LEN_W   (LEN_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .pre_len_i     (pre_len_i),
    .sfd_i         (sfd_i),
    .sym_en_i      (sym_en_i),
    .up_data_i     (up_data_i),
    .up_valid_i    (up_valid_i),
    .up_last_i     (up_last_i),
    .up_ready_o    (up_ready_o),
    .bit_o         (bit_o),
    .bit_vld_o     (bit_vld_o),
    .force_dbpsk_o (force_dbpsk_o)
);

// File: tb/frame_sync_gen_tb.sv
module frame_sync_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB       = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [8:0]  pre_len = '0;
    logic [15:0] sfd = '0;
    logic        sym_en = 1'b0;
    logic        up_data = 1'b0;
    logic        up_valid = 1'b0;
    logic        up_last = 1'b0;
    logic        up_ready, bit_o, bit_vld, force_o;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    logic ob [MAXB];
    logic of [MAXB];
    int   ocnt   = 0;
    int   orphan = 0;

    frame_sync_gen u_dut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .pre_len_i     (pre_len),
        .sfd_i         (sfd),
        .sym_en_i      (sym_en),
        .up_data_i     (up_data),
        .up_valid_i    (up_valid),
        .up_last_i     (up_last),
        .up_ready_o    (up_ready),
        .bit_o         (bit_o),
        .bit_vld_o     (bit_vld),
        .force_dbpsk_o (force_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Output monitor, a quarter period after each rising edge.
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (bit_vld) begin
            if (ocnt < MAXB) begin
                ob[ocnt] = bit_o;
                of[ocnt] = force_o;
            end
            ocnt++;
            if (!sym_en) orphan++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [8:0] l);
        if (l == 0) return 1;
        if (l > 256) return 256;
        return int'(l);
    endfunction

    function automatic logic exp_bit(input int i, input int l, input logic [15:0] p,
                                     input logic [63:0] pay);
        if (i < l) return 1'b1;
        if (i < l + 16) return p[i - l];
        return pay[i - l - 16];
    endfunction

    task automatic run_frame(input logic [8:0] len, input logic [15:0] pat,
                             input int nbits, input logic [63:0] pay,
                             input int sym_pct, input int val_pct,
                             input bit mid_start, input string tag);
        int  ptr = 0;
        bit  hs = 1'b0;
        int  cyc = 0;
        int  l = exp_len(len);
        int  total = l + 16 + nbits;
        int  bad_pre = 0, bad_sfd = 0, bad_dat = 0, bad_frc = 0;
        int  cnt_end;
        @(negedge clk);
        ocnt = 0; orphan = 0;
        start = 1'b1; pre_len = len; sfd = pat; sym_en = 1'b0; up_valid = 1'b0;
        @(negedge clk);
        start = 1'b0; pre_len = 9'($urandom); sfd = 16'($urandom);
        // R6: forcing is raised right after the start is accepted
        chk(force_o == 1'b1 && bit_vld == 1'b0, "R6", {tag, " force after start"},
            int'(force_o), 1);
        while (ocnt < total && cyc < 5000) begin
            if (hs) ptr++;
            sym_en = (($urandom % 100) < sym_pct);
            if (ptr < nbits) begin
                up_valid = (($urandom % 100) < val_pct);
                up_data  = pay[ptr];
                up_last  = (ptr == nbits - 1);
            end else begin
                up_valid = 1'b0;
                up_last  = 1'b0;
            end
            start = mid_start && (cyc == 40);
            if (start) begin
                pre_len = 9'd3;
                sfd     = ~pat;
            end
            #1 hs = up_valid && up_ready;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; up_valid = 1'b0; up_last = 1'b0; sym_en = 1'b1;
        repeat (30) @(negedge clk);
        sym_en = 1'b0;
        @(negedge clk);
        cnt_end = ocnt;
        for (int i = 0; i < total && i < MAXB; i++) begin
            if (ob[i] !== exp_bit(i, l, pat, pay)) begin
                if (i < l) bad_pre++;
                else if (i < l + 16) bad_sfd++;
                else bad_dat++;
            end
            if (of[i] !== (i < l + 16)) bad_frc++;
        end
        chk(cnt_end == total, mid_start ? "R2" : "R5", {tag, " bits in frame"}, cnt_end, total);
        chk(bad_pre == 0, "R3", {tag, " preamble mismatches"}, bad_pre, 0);
        chk(bad_sfd == 0, "R4", {tag, " start word mismatches"}, bad_sfd, 0);
        chk(bad_dat == 0, "R5", {tag, " data mismatches"}, bad_dat, 0);
        chk(bad_frc == 0, "R6", {tag, " force flag mismatches"}, bad_frc, 0);
        chk(orphan == 0, "R7", {tag, " bits without symbol enable"}, orphan, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        sym_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1 and R8: quiet during reset even with symbol enables present
        chk(bit_vld == 1'b0, "R1", "vld in reset", int'(bit_vld), 0);
        chk(force_o == 1'b0, "R1", "force in reset", int'(force_o), 0);
        chk(up_ready == 1'b0, "R8", "ready in reset", int'(up_ready), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(bit_vld == 1'b0 && up_ready == 1'b0, "R1", "idle after reset",
            int'(bit_vld), 0);
        sym_en = 1'b0;

        // Directed corners
        run_frame(9'd1,   16'hF3A0, 8,  64'hA5, 100, 100, 1'b0, "len1");
        run_frame(9'd256, 16'hF3A0, 16, 64'h1234, 100, 100, 1'b0, "len256");
        run_frame(9'd0,   16'h8001, 4,  64'h9, 100, 100, 1'b0, "len0");
        run_frame(9'd300, 16'h0F0F, 1,  64'h1, 100, 100, 1'b0, "len300");
        run_frame(9'd128, 16'hC35A, 20, 64'hDEADB, 100, 100, 1'b1, "midstart");
        run_frame(9'd5,   16'h7E81, 40, {$urandom, $urandom}, 100, 20, 1'b0, "underrun_R8");
        run_frame(9'd12,  16'hFFFF, 64, {$urandom, $urandom}, 25, 100, 1'b0, "sparse_R7");

        // Constrained random frames
        for (int k = 0; k < 12; k++) begin
            run_frame(9'(1 + $urandom % 64), 16'($urandom), 1 + int'($urandom % 64),
                      {$urandom, $urandom}, 30 + int'($urandom % 71),
                      40 + int'($urandom % 61), 1'b0, "rand");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule